// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block sits next to an asynchronous serial receiver and tells software when a variable-length frame has ended. It watches a one-bit-period tick and a strobe that the receiver raises when a character has been fully received. After each received character it starts counting bit periods of idle line. When a programmed number of bit periods passes with no new character, it raises a sticky idle status flag. An interrupt request follows that flag whenever the interrupt enable is high.

The idle limit is a 16-bit count of bit periods. A limit of zero turns detection off completely. Counting begins only after the first character that follows reset or a restart command, so an idle line before any data never causes a timeout. The restart command clears the flag and waits for the next character. A new limit written while a count is running takes effect at the next received character.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset, idle_flag and idle_irq are 0 and no count is running.
- R2: While idle_limit is 0, idle_flag is 0 from the next cycle on, whatever the other inputs do. This includes clearing a flag that was already set.
- R3: After reset or a restart, bit ticks do not set idle_flag until a char_done strobe has been accepted.
- R4: With a non-zero limit N loaded by char_done, idle_flag rises on the clock edge of the N-th following cycle that has bit_tick high. It does not rise on any earlier edge.
- R5: Each char_done with a non-zero limit reloads the count to the limit. Idle time is therefore always measured from the most recent character.
- R6: When char_done and the bit_tick that would expire the count arrive in the same cycle, the reload wins and idle_flag stays 0.
- R7: Once set, idle_flag stays 1 until restart is high at a clock edge. That restart clears the flag and stops the count.
- R8: idle_irq equals idle_flag AND irq_en in every cycle.
- R9: A change of idle_limit while a count is running does not change that count. The new value is loaded at the next char_done.
- R10: restart has priority over char_done and over expiry in the same cycle. After such a cycle, idle_flag is 0 and no count runs.
- R11: Cycles without bit_tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_done | input | 1 | One-cycle pulse when the receiver completes a character |
| idle_limit | input | 16 | Idle timeout in bit periods; 0 disables detection |
| restart | input | 1 | Clears the flag and waits for the next character |
| irq_en | input | 1 | Interrupt enable |
| idle_flag | output | 1 | Sticky end-of-frame status |
| idle_irq | output | 1 | Interrupt request, idle_flag gated by irq_en |

## Verification
Two functions can land in the same cycle: the reload from a new character, and the final bit tick that would expire the count. A restart can also coincide with either of them. The directed sequences bring the count to one remaining period and then apply tick together with char_done, or tick together with restart. The flag is checked to stay low, and the count is then checked to restart from the full limit. Random stimulus makes these collisions often by using short limits and dense strobes. Every cycle is judged against a bench model that applies the stated priority of restart, then disable, then reload, then decrement.

// File: rtl/uit_pkg.sv
package uit_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_DISARM,
    ACT_LOAD,
    ACT_DEC,
    ACT_EXPIRE
  } uit_act_e;

  // Priority: restart, disabled limit, reload, countdown.
  function automatic uit_act_e uit_pick_act(
    input logic restart,
    input logic limit_zero,
    input logic char_done,
    input logic armed,
    input logic tick,
    input logic last_one
  );
    if (restart || limit_zero)   return ACT_DISARM;
    if (char_done)               return ACT_LOAD;
    if (armed && tick && last_one) return ACT_EXPIRE;
    if (armed && tick)           return ACT_DEC;
    return ACT_HOLD;
  endfunction
endpackage

// File: rtl/uit_counter.sv
module uit_counter
  import uit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_done,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             armed,
  output logic             expire_evt,
  output logic             disarm_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             limit_zero;
  uit_act_e         act;

  assign limit_zero = (limit == '0);
  assign act = uit_pick_act(restart, limit_zero, char_done, armed_q,
                            bit_tick, cnt_q == ONE);
  assign expire_evt = (act == ACT_EXPIRE);
  assign disarm_evt = (act == ACT_DISARM);
  assign armed      = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (act)
        ACT_DISARM: armed_q <= 1'b0;
        ACT_LOAD: begin
          armed_q <= 1'b1;
          cnt_q   <= limit;
        end
        ACT_EXPIRE: begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end
        ACT_DEC:  cnt_q <= cnt_q - ONE;
        default: ;
      endcase
    end
  end

  AST_RELOAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !restart && limit != '0) |=> (armed_q && cnt_q == $past(limit))); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !char_done && !restart && limit != '0) |=> $stable(cnt_q)); // R11
  AST_RESTART_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !armed_q); // R10
endmodule

// File: rtl/uit_status.sv
module uit_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clr_evt) flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

  AST_FLAG_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q); // R7
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_done,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic             restart,
  input  logic             irq_en,
  output logic             idle_flag,
  output logic             idle_irq
);
  logic armed;
  logic expire_evt;
  logic disarm_evt;

  uit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .char_done  (char_done),
    .restart    (restart),
    .limit      (idle_limit),
    .armed      (armed),
    .expire_evt (expire_evt),
    .disarm_evt (disarm_evt)
  );

  uit_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (expire_evt),
    .clr_evt (disarm_evt),
    .irq_en  (irq_en),
    .flag    (idle_flag),
    .irq     (idle_irq)
  );

  AST_EXPIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |-> armed); // R3
  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_limit == '0) |=> !idle_flag); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !idle_flag); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |-> (idle_flag && irq_en)); // R8
endmodule

// File: tb/uart_idle_timeout_bench.sv
module uart_idle_timeout_bench;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, char_done = 1'b0, restart = 1'b0, irq_en = 1'b0;
  logic [CNT_W-1:0] idle_limit = '0;
  logic idle_flag, idle_irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit m_arm = 0, m_flag = 0;
  int m_left = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_idle_timeout #(.CNT_W(CNT_W)) u_uart_idle_timeout (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_done(char_done),
    .idle_limit(idle_limit), .restart(restart), .irq_en(irq_en),
    .idle_flag(idle_flag), .idle_irq(idle_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Model of the requirement priorities: restart, zero limit, reload, tick.
  function automatic void model_step(bit t, bit c, bit r, int lim);
    if (r || lim == 0) begin
      m_arm = 0; m_flag = 0;
    end else if (c) begin
      m_arm = 1; m_left = lim;
    end else if (m_arm && t) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_arm = 0; m_flag = 1; end
    end
  endfunction

  // Called at a negedge: drive, advance model, wait one cycle.
  task automatic step(input bit t, input bit c, input bit r);
    bit_tick = t; char_done = c; restart = r;
    if (rst_n) model_step(t, c, r, int'(idle_limit));
    @(negedge clk);
    bit_tick = 0; char_done = 0; restart = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1d1e));
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", idle_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", idle_flag, 1'b0);
    chk("R1 irq after reset", idle_irq, 1'b0);

    // R3: ticks before any character
    idle_limit = 3; irq_en = 1;
    ticks(10);
    chk("R3 no timeout before first char", idle_flag, 1'b0);

    // R4: exact expiry
    step(0, 1, 0);
    ticks(2);
    chk("R4 not yet after N-1 ticks", idle_flag, 1'b0);
    ticks(1);
    chk("R4 set after N ticks", idle_flag, 1'b1);
    chk("R8 irq with enable", idle_irq, 1'b1);
    irq_en = 0; #1;
    chk("R8 irq masked", idle_irq, 1'b0);
    irq_en = 1;

    // R7: sticky then restart
    ticks(5); step(0, 1, 0); ticks(2);
    chk("R7 flag sticky", idle_flag, 1'b1);
    step(0, 0, 1);
    chk("R7 restart clears", idle_flag, 1'b0);
    ticks(6);
    chk("R7 R3 no count after restart", idle_flag, 1'b0);

    // R11: idle cycles without tick
    step(0, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0);
    ticks(2);
    chk("R11 no count without tick", idle_flag, 1'b0);
    ticks(1);
    chk("R11 expires after ticks only", idle_flag, 1'b1);
    step(0, 0, 1);

    // R5: reload restarts measure
    step(0, 1, 0); ticks(2); step(0, 1, 0); ticks(2);
    chk("R5 reload restarted count", idle_flag, 1'b0);
    ticks(1);
    chk("R5 expires from last char", idle_flag, 1'b1);
    step(0, 0, 1);

    // R6: char with final tick
    step(0, 1, 0); ticks(2); step(1, 1, 0);
    chk("R6 reload wins over expiry", idle_flag, 1'b0);
    ticks(2);
    chk("R6 full reload", idle_flag, 1'b0);
    ticks(1);
    chk("R6 expires after reload", idle_flag, 1'b1);
    step(0, 0, 1);

    // R9: limit change mid-count
    step(0, 1, 0); idle_limit = 6; ticks(3);
    chk("R9 old limit still used", idle_flag, 1'b1);
    step(0, 0, 1); step(0, 1, 0); ticks(5);
    chk("R9 new limit not yet", idle_flag, 1'b0);
    ticks(1);
    chk("R9 new limit at char", idle_flag, 1'b1);

    // R10: restart collisions
    step(0, 0, 1); idle_limit = 2;
    step(0, 1, 0); ticks(1); step(1, 0, 1);
    chk("R10 restart beats expiry", idle_flag, 1'b0);
    step(0, 1, 1); ticks(4);
    chk("R10 restart beats char", idle_flag, 1'b0);

    // R2: zero limit
    step(0, 1, 0); ticks(2);
    chk("R2 precondition flag", idle_flag, 1'b1);
    idle_limit = 0; step(0, 0, 0);
    chk("R2 zero clears flag", idle_flag, 1'b0);
    step(0, 1, 0); ticks(5);
    chk("R2 zero never flags", idle_flag, 1'b0);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 40) == 0) idle_limit = CNT_W'($urandom % 6);
      if (($urandom % 25) == 0) irq_en = ~irq_en;
      step(($urandom % 2) == 0, ($urandom % 7) == 0, ($urandom % 30) == 0);
      chk("R4 random flag", idle_flag, m_flag);
      chk("R8 random irq", idle_irq, m_flag & irq_en);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule